// File: doc/BRIEF.md
# SPI FIFO Interrupt and Status Unit

This block sits beside the transmit and receive FIFOs of an SPI controller and turns their traffic into software-visible state. It counts the entries in each FIFO from push and pop strobes. It reports those counts and a packed status word, and it detects overflow and underflow on the FIFO ports. From all of this it builds a raw interrupt vector, a mask, a masked vector and a single interrupt line.

The receive threshold-full interrupt fires when the receive count rises above a programmable threshold. It does not wait for the FIFO to be completely full, so a handler can be woken for a partial block. Error bits stay set until software writes the clear register. That register has its own bit layout and includes a clear-all bit.

Clearing the enable register flushes both FIFOs: the counts and the sticky bits return to zero, and FIFO events are ignored until the block is enabled again. The threshold register can only be written while the block is disabled.

Top module: `spi_fifo_irq_status`

## Requirements
- R1: After reset the following values hold:
  - enable (0x0), threshold (0x1), mask (0x5) and both levels (0x2 transmit, 0x3 receive) read 0.
  - status (0x4) reads 0x0C and raw (0x7) reads 0x01.
  - `irq_o` is 0, `ctl_en_o` is 0 and `fifo_flush_o` is 1.
- R2: While enabled, the FIFO levels change as follows:
  - a push adds one to its level and a pop removes one;
  - a push and a pop in the same cycle leave a non-empty level unchanged;
  - levels are read at address 0x2 (transmit) and 0x3 (receive).
- R3: The status word at address 0x4 has these bits:
  - bit 0 is `busy_i`;
  - bit 1 is transmit full (level equals depth);
  - bit 2 is transmit empty;
  - bit 3 is receive empty;
  - bit 4 is receive full;
  - bit 5 is `tgt_busy_i`.
- R4: A push at full level with no pop in the same cycle keeps the level at depth and sets a sticky raw bit. The raw vector is at address 0x7. The bit is bit 1 for the transmit side and bit 3 for the receive side.
- R5: A receive pop at level 0 sets sticky raw bit 2. If a push comes in the same cycle, the receive level becomes 1.
- R6: Two raw bits follow the current levels. Raw bit 0 is 1 exactly when the transmit level is 0. Raw bit 4 is 1 exactly when the receive level is greater than the threshold. Raw bit 5 always reads 0.
- R7: A write to address 0x8 clears sticky bits as follows:
  - data bit 0 clears all sticky bits;
  - bit 1 clears raw bit 2;
  - bit 2 clears raw bit 3;
  - bit 3 clears raw bit 1.
  A sticky event in the same cycle as a clear wins, and the bit stays set.
- R8: The masked vector at address 0x6 equals raw AND mask, where the mask is written at address 0x5. `irq_o` is the OR of the masked bits.
- R9: A write to the threshold at address 0x1 (data bits [log2(depth)-1:0]) takes effect only while disabled. While enabled it is ignored.
- R10: Writing 0 to enable (address 0x0, bit 0) flushes the block:
  - one cycle later both levels and all sticky bits are 0;
  - FIFO and chip-select events have no effect while disabled;
  - `fifo_flush_o` is high while disabled.
- R11: A pulse on `cs_inactive_i` while enabled sets sticky raw bit 6. Only the clear-all bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address for write and read |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i |
| tx_push_i | input | 1 | Word written into the transmit FIFO |
| tx_pop_i | input | 1 | Word taken from the transmit FIFO by the serial engine |
| rx_push_i | input | 1 | Word written into the receive FIFO by the serial engine |
| rx_pop_i | input | 1 | Word read from the receive FIFO |
| busy_i | input | 1 | Serial engine busy |
| tgt_busy_i | input | 1 | Target-mode transmit busy |
| cs_inactive_i | input | 1 | Chip select went inactive (pulse) |
| ctl_en_o | output | 1 | Controller enabled |
| fifo_flush_o | output | 1 | Hold FIFO storage empty |
| irq_o | output | 1 | Interrupt request |

## Verification
A clear-register write and a fresh sticky event can land on the same clock edge; the bench pulses `cs_inactive_i` in the very cycle that the clear-all bit is written and expects raw bit 6 still set afterward. A second collision is a push and a pop together at a full or empty FIFO, which must neither count nor flag an overflow at full, but must flag underflow and still count the push at empty. Every step is compared against an arithmetic model of levels, sticky bits, threshold and mask kept in the bench.

// File: rtl/spi_fis_pkg.sv
package spi_fis_pkg;

   localparam int REG_AW = 4;
   localparam int IRQ_W  = 7;
   localparam int STAT_W = 6;
   localparam int CLR_W  = 4;

   // register addresses
   localparam logic [REG_AW-1:0] RA_ENABLE = 4'h0;
   localparam logic [REG_AW-1:0] RA_RXTHR  = 4'h1;
   localparam logic [REG_AW-1:0] RA_TXLVL  = 4'h2;
   localparam logic [REG_AW-1:0] RA_RXLVL  = 4'h3;
   localparam logic [REG_AW-1:0] RA_STATUS = 4'h4;
   localparam logic [REG_AW-1:0] RA_MASK   = 4'h5;
   localparam logic [REG_AW-1:0] RA_MASKED = 4'h6;
   localparam logic [REG_AW-1:0] RA_RAW    = 4'h7;
   localparam logic [REG_AW-1:0] RA_CLEAR  = 4'h8;

   // interrupt vector bit positions
   localparam int IB_TXE = 0;
   localparam int IB_TXO = 1;
   localparam int IB_RXU = 2;
   localparam int IB_RXO = 3;
   localparam int IB_RXF = 4;
   localparam int IB_CSI = 6;

   // status word bit positions
   localparam int SB_BUSY = 0;
   localparam int SB_TXF  = 1;
   localparam int SB_TXE  = 2;
   localparam int SB_RXE  = 3;
   localparam int SB_RXF  = 4;
   localparam int SB_TBSY = 5;

   // clear register bit positions
   localparam int CB_ALL = 0;
   localparam int CB_RXU = 1;
   localparam int CB_RXO = 2;
   localparam int CB_TXO = 3;

   typedef enum logic [1:0] {BK_NONE, BK_LEVEL, BK_STICKY} bit_kind_e;

   // behaviour of each interrupt bit
   function automatic bit_kind_e irq_kind(int idx);
      case (idx)
         IB_TXE, IB_RXF:                 return BK_LEVEL;
         IB_TXO, IB_RXU, IB_RXO, IB_CSI: return BK_STICKY;
         default:                        return BK_NONE;
      endcase
   endfunction

   // dedicated clear bit for an interrupt bit, -1 when only clear-all applies
   function automatic int irq_clr_sel(int idx);
      case (idx)
         IB_TXO:  return CB_TXO;
         IB_RXU:  return CB_RXU;
         IB_RXO:  return CB_RXO;
         default: return -1;
      endcase
   endfunction

endpackage

// File: rtl/spi_fis_level.sv
module spi_fis_level #(
   parameter int DEPTH = 32,
   parameter int LVL_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             push_i,
   input  logic             pop_i,
   output logic [LVL_W-1:0] level_o,
   output logic             full_o,
   output logic             empty_o,
   output logic             ovf_o,
   output logic             unf_o
);

   localparam logic [LVL_W-1:0] TOP = LVL_W'(DEPTH);
   localparam logic [LVL_W-1:0] ONE = LVL_W'(1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spi_fis_level: DEPTH must be at least 2");
   end
   if ((1 << (LVL_W - 1)) < DEPTH) begin : g_bad_lvl
      $error("spi_fis_level: LVL_W too narrow for DEPTH");
   end

   logic [LVL_W-1:0] lvl_q;
   logic [LVL_W-1:0] lvl_d;

   assign full_o  = (lvl_q == TOP);
   assign empty_o = (lvl_q == '0);
   assign ovf_o   = run_i & push_i & ~pop_i & full_o;
   assign unf_o   = run_i & pop_i & empty_o;
   assign level_o = lvl_q;

   always_comb begin
      lvl_d = lvl_q;
      case ({push_i, pop_i})
         2'b10:   if (!full_o)  lvl_d = lvl_q + ONE;
         2'b01:   if (!empty_o) lvl_d = lvl_q - ONE;
         2'b11:   if (empty_o)  lvl_d = lvl_q + ONE;
         default: lvl_d = lvl_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl_q <= '0;
      else if (!run_i) lvl_q <= '0;
      else             lvl_q <= lvl_d;
   end

endmodule

// File: rtl/spi_fis_irq.sv
module spi_fis_irq
   import spi_fis_pkg::*;
#(
   parameter int N_IRQ = IRQ_W,
   parameter int N_CLR = CLR_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [N_IRQ-1:0] src_i,
   input  logic             clr_wr_i,
   input  logic [N_CLR-1:0] clr_data_i,
   input  logic [N_IRQ-1:0] mask_i,
   output logic [N_IRQ-1:0] raw_o,
   output logic [N_IRQ-1:0] masked_o,
   output logic             irq_o
);

   if (N_IRQ <= IB_CSI) begin : g_bad_width
      $error("spi_fis_irq: N_IRQ too small for the interrupt map");
   end
   if (N_CLR <= CB_TXO) begin : g_bad_clr
      $error("spi_fis_irq: N_CLR too small for the clear map");
   end

   for (genvar g = 0; g < N_IRQ; g++) begin : g_bit
      localparam bit_kind_e KIND = irq_kind(g);
      localparam int        CSEL = irq_clr_sel(g);

      if (KIND == BK_STICKY) begin : g_sticky
         logic own_clr;
         logic flag_q;
         if (CSEL >= 0) begin : g_sel
            assign own_clr = clr_data_i[CSEL];
         end else begin : g_nosel
            assign own_clr = 1'b0;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                          flag_q <= 1'b0;
            else if (!run_i)                                     flag_q <= 1'b0;
            else if (src_i[g])                                   flag_q <= 1'b1;
            else if (clr_wr_i && (clr_data_i[CB_ALL] || own_clr)) flag_q <= 1'b0;
         end
         assign raw_o[g] = flag_q;
      end else if (KIND == BK_LEVEL) begin : g_level
         assign raw_o[g] = src_i[g];
      end else begin : g_none
         logic unused_src;
         assign unused_src = src_i[g];
         assign raw_o[g]   = 1'b0;
      end
   end

   assign masked_o = raw_o & mask_i;
   assign irq_o    = |masked_o;

endmodule

// File: rtl/spi_fis_regs.sv
module spi_fis_regs
   import spi_fis_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int TH_W   = 5,
   parameter int LVL_W  = 6,
   parameter int N_IRQ  = IRQ_W,
   parameter int N_STAT = STAT_W,
   parameter int N_CLR  = CLR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [REG_AW-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              en_o,
   output logic [TH_W-1:0]   thr_o,
   output logic [N_IRQ-1:0]  mask_o,
   output logic              clr_wr_o,
   output logic [N_CLR-1:0]  clr_data_o,
   input  logic [LVL_W-1:0]  tx_lvl_i,
   input  logic [LVL_W-1:0]  rx_lvl_i,
   input  logic [N_STAT-1:0] status_i,
   input  logic [N_IRQ-1:0]  raw_i,
   input  logic [N_IRQ-1:0]  masked_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int USED_W = (TH_W > N_IRQ) ? TH_W : N_IRQ;

   if (DATA_W <= USED_W || DATA_W < LVL_W) begin : g_bad_dw
      $error("spi_fis_regs: DATA_W too narrow");
   end

   logic             en_q;
   logic [TH_W-1:0]  thr_q;
   logic [N_IRQ-1:0] mask_q;
   logic             unused_wdata;

   assign unused_wdata = ^wdata_i[DATA_W-1:USED_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         thr_q  <= '0;
         mask_q <= '0;
      end else if (wr_i) begin
         case (addr_i)
            RA_ENABLE: en_q <= wdata_i[0];
            RA_RXTHR:  if (!en_q) thr_q <= wdata_i[TH_W-1:0];
            RA_MASK:   mask_q <= wdata_i[N_IRQ-1:0];
            default:   ;
         endcase
      end
   end

   assign en_o       = en_q;
   assign thr_o      = thr_q;
   assign mask_o     = mask_q;
   assign clr_wr_o   = wr_i && (addr_i == RA_CLEAR);
   assign clr_data_o = wdata_i[N_CLR-1:0];

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         RA_ENABLE: rdata_o = DATA_W'(en_q);
         RA_RXTHR:  rdata_o = DATA_W'(thr_q);
         RA_TXLVL:  rdata_o = DATA_W'(tx_lvl_i);
         RA_RXLVL:  rdata_o = DATA_W'(rx_lvl_i);
         RA_STATUS: rdata_o = DATA_W'(status_i);
         RA_MASK:   rdata_o = DATA_W'(mask_q);
         RA_MASKED: rdata_o = DATA_W'(masked_i);
         RA_RAW:    rdata_o = DATA_W'(raw_i);
         default:   rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/spi_fifo_irq_status.sv
module spi_fifo_irq_status
   import spi_fis_pkg::*;
#(
   parameter int FIFO_DEPTH = 32,
   parameter int DATA_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic [REG_AW-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              tx_push_i,
   input  logic              tx_pop_i,
   input  logic              rx_push_i,
   input  logic              rx_pop_i,
   input  logic              busy_i,
   input  logic              tgt_busy_i,
   input  logic              cs_inactive_i,
   output logic              ctl_en_o,
   output logic              fifo_flush_o,
   output logic              irq_o
);

   localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;
   localparam int TH_W  = $clog2(FIFO_DEPTH);

   if (FIFO_DEPTH != 32 && FIFO_DEPTH != 64) begin : g_bad_depth
      $error("spi_fifo_irq_status: FIFO_DEPTH must be 32 or 64");
   end
   if (DATA_W < 16) begin : g_bad_dw
      $error("spi_fifo_irq_status: DATA_W must be at least 16");
   end

   logic              en_q;
   logic [TH_W-1:0]   thr_q;
   logic [IRQ_W-1:0]  mask_q;
   logic              clr_wr;
   logic [CLR_W-1:0]  clr_data;
   logic [LVL_W-1:0]  tx_level, rx_level;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic              tx_ovf, rx_ovf, rx_unf;
   logic              tx_unused_unf;
   logic              rx_thr_hit;
   logic [IRQ_W-1:0]  src_vec, raw_vec, masked_vec;
   logic [STAT_W-1:0] status_vec;

   spi_fis_level #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_tx_lvl (
      .clk(clk), .rst_n(rst_n), .run_i(en_q),
      .push_i(tx_push_i), .pop_i(tx_pop_i),
      .level_o(tx_level), .full_o(tx_full), .empty_o(tx_empty),
      .ovf_o(tx_ovf), .unf_o(tx_unused_unf)
   );

   spi_fis_level #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_rx_lvl (
      .clk(clk), .rst_n(rst_n), .run_i(en_q),
      .push_i(rx_push_i), .pop_i(rx_pop_i),
      .level_o(rx_level), .full_o(rx_full), .empty_o(rx_empty),
      .ovf_o(rx_ovf), .unf_o(rx_unf)
   );

   assign rx_thr_hit = (rx_level > {1'b0, thr_q});

   always_comb begin
      src_vec         = '0;
      src_vec[IB_TXE] = tx_empty;
      src_vec[IB_TXO] = tx_ovf;
      src_vec[IB_RXU] = rx_unf;
      src_vec[IB_RXO] = rx_ovf;
      src_vec[IB_RXF] = rx_thr_hit;
      src_vec[IB_CSI] = cs_inactive_i;
   end

   always_comb begin
      status_vec          = '0;
      status_vec[SB_BUSY] = busy_i;
      status_vec[SB_TXF]  = tx_full;
      status_vec[SB_TXE]  = tx_empty;
      status_vec[SB_RXE]  = rx_empty;
      status_vec[SB_RXF]  = rx_full;
      status_vec[SB_TBSY] = tgt_busy_i;
   end

   spi_fis_irq #(.N_IRQ(IRQ_W), .N_CLR(CLR_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .run_i(en_q),
      .src_i(src_vec), .clr_wr_i(clr_wr), .clr_data_i(clr_data),
      .mask_i(mask_q), .raw_o(raw_vec), .masked_o(masked_vec), .irq_o(irq_o)
   );

   spi_fis_regs #(
      .DATA_W(DATA_W), .TH_W(TH_W), .LVL_W(LVL_W),
      .N_IRQ(IRQ_W), .N_STAT(STAT_W), .N_CLR(CLR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
      .en_o(en_q), .thr_o(thr_q), .mask_o(mask_q),
      .clr_wr_o(clr_wr), .clr_data_o(clr_data),
      .tx_lvl_i(tx_level), .rx_lvl_i(rx_level),
      .status_i(status_vec), .raw_i(raw_vec), .masked_i(masked_vec),
      .rdata_o(reg_rdata_o)
   );

   assign ctl_en_o     = en_q;
   assign fifo_flush_o = ~en_q;

endmodule

// File: rtl/spi_fis_chk.sv
module spi_fis_chk
   import spi_fis_pkg::*;
#(
   parameter int FIFO_DEPTH = 32,
   parameter int LVL_W      = 6,
   parameter int TH_W       = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_i,
   input logic [REG_AW-1:0] reg_addr_i,
   input logic [CLR_W-1:0]  clr_bits,
   input logic              tx_push_i,
   input logic              tx_pop_i,
   input logic              rx_push_i,
   input logic              rx_pop_i,
   input logic              en_q,
   input logic [TH_W-1:0]   thr_q,
   input logic [LVL_W-1:0]  tx_level,
   input logic [LVL_W-1:0]  rx_level,
   input logic [IRQ_W-1:0]  raw_vec
);

   logic clr_txo_hit;
   assign clr_txo_hit = reg_wr_i && (reg_addr_i == RA_CLEAR) &&
                        (clr_bits[CB_ALL] || clr_bits[CB_TXO]);

   // R2
   tx_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q && tx_push_i && !tx_pop_i && (tx_level < LVL_W'(FIFO_DEPTH))
      |=> tx_level == $past(tx_level) + LVL_W'(1));

   // R4
   tx_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q && tx_push_i && !tx_pop_i && (tx_level == LVL_W'(FIFO_DEPTH))
      |=> raw_vec[IB_TXO] && (tx_level == LVL_W'(FIFO_DEPTH)));

   // R5
   rx_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q && rx_pop_i && (rx_level == '0) |=> raw_vec[IB_RXU]);

   // R7
   txo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q && raw_vec[IB_TXO] && !clr_txo_hit |=> raw_vec[IB_TXO]);

   // R9
   thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> $stable(thr_q));

   // R10
   off_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> (tx_level == '0) && (rx_level == '0) &&
                !raw_vec[IB_TXO] && !raw_vec[IB_RXO] &&
                !raw_vec[IB_RXU] && !raw_vec[IB_CSI]);

endmodule

bind spi_fifo_irq_status spi_fis_chk #(
   .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .TH_W(TH_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
   .clr_bits(reg_wdata_i[spi_fis_pkg::CLR_W-1:0]),
   .tx_push_i(tx_push_i), .tx_pop_i(tx_pop_i),
   .rx_push_i(rx_push_i), .rx_pop_i(rx_pop_i),
   .en_q(en_q), .thr_q(thr_q),
   .tx_level(tx_level), .rx_level(rx_level), .raw_vec(raw_vec)
);

// File: tb/spi_fifo_irq_status_tb.sv
module spi_fifo_irq_status_tb;

   localparam int CLK_PERIOD = 20;
   localparam int D          = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic        busy = 1'b0, tgt_busy = 1'b0, cs_inact = 1'b0;
   logic        ctl_en, fifo_flush, irq;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 0;

   // bench model
   int         m_tx = 0, m_rx = 0, m_thr = 0;
   logic [6:0] m_stk = '0, m_mask = '0;
   bit         m_en = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_fifo_irq_status #(.FIFO_DEPTH(D), .DATA_W(32)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
      .reg_rdata_o(reg_rdata),
      .tx_push_i(tx_push), .tx_pop_i(tx_pop),
      .rx_push_i(rx_push), .rx_pop_i(rx_pop),
      .busy_i(busy), .tgt_busy_i(tgt_busy), .cs_inactive_i(cs_inact),
      .ctl_en_o(ctl_en), .fifo_flush_o(fifo_flush), .irq_o(irq)
   );

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   function automatic int nxt(int l, bit pu, bit po);
      if (pu && !po) return (l < D) ? l + 1 : l;
      if (po && !pu) return (l > 0) ? l - 1 : 0;
      if (pu && po && l == 0) return 1;
      return l;
   endfunction

   // one clock cycle of stimulus, starting and ending at a falling edge
   task automatic cyc(bit tp, bit tpo, bit rp, bit rpo, bit csi,
                      bit wr, logic [3:0] a, logic [31:0] d);
      bit         old_en;
      logic [6:0] set;
      tx_push = tp; tx_pop = tpo; rx_push = rp; rx_pop = rpo; cs_inact = csi;
      reg_wr = wr; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; cs_inact = 0; reg_wr = 0;
      old_en = m_en;
      if (old_en) begin
         set = '0;
         if (tp && !tpo && m_tx == D) set[1] = 1'b1;
         if (rp && !rpo && m_rx == D) set[3] = 1'b1;
         if (rpo && m_rx == 0)        set[2] = 1'b1;
         if (csi)                     set[6] = 1'b1;
         if (wr && a == 4'h8) begin
            if (d[0]) m_stk = '0;
            if (d[1]) m_stk[2] = 1'b0;
            if (d[2]) m_stk[3] = 1'b0;
            if (d[3]) m_stk[1] = 1'b0;
         end
         m_stk = m_stk | set;
         m_tx  = nxt(m_tx, tp, tpo);
         m_rx  = nxt(m_rx, rp, rpo);
      end else begin
         m_tx = 0; m_rx = 0; m_stk = '0;
      end
      if (wr) begin
         case (a)
            4'h0: m_en = d[0];
            4'h1: if (!old_en) m_thr = int'(d[4:0]);
            4'h5: m_mask = d[6:0];
            default: ;
         endcase
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      cyc(0, 0, 0, 0, 0, 1, a, d);
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 4'h0, 32'h0);
   endtask

   task automatic check_all(string req);
      logic [31:0] v;
      logic [6:0]  er;
      logic [5:0]  es;
      er    = m_stk;
      er[0] = (m_tx == 0);
      er[4] = (m_rx > m_thr);
      es    = {tgt_busy, m_rx == D, m_rx == 0, m_tx == 0, m_tx == D, busy};
      rd(4'h2, v); chk({req, " tx level"}, v, 32'(m_tx));
      rd(4'h3, v); chk({req, " rx level"}, v, 32'(m_rx));
      rd(4'h4, v); chk({req, " status"}, v, 32'(es));
      rd(4'h7, v); chk({req, " raw"}, v, 32'(er));
      rd(4'h6, v); chk({req, " masked"}, v, 32'(er & m_mask));
      chk({req, " irq"}, 32'(irq), 32'(|(er & m_mask)));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_all("R1");
      rd(4'h0, v); chk("R1 enable", v, 0);
      rd(4'h1, v); chk("R1 threshold", v, 0);
      rd(4'h5, v); chk("R1 mask", v, 0);
      rd(4'h4, v); chk("R1 status literal", v, 32'h0C);
      rd(4'h7, v); chk("R1 raw literal", v, 32'h01);
      chk("R1 ctl_en", 32'(ctl_en), 0);
      chk("R1 flush", 32'(fifo_flush), 1);

      // R10 events ignored while disabled
      for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, 1, 0, 4'h0, 0);
      check_all("R10 disabled push");

      // threshold accepted while disabled (R9), then enable
      wr(4'h1, 32'd3);
      rd(4'h1, v); chk("R9 thr write disabled", v, 3);
      wr(4'h0, 32'd1);
      chk("R10 flush low when enabled", 32'(fifo_flush), 0);
      chk("R10 ctl_en", 32'(ctl_en), 1);

      // R2 R3 transmit fill sweep
      for (int i = 0; i < D; i++) begin
         cyc(1, 0, 0, 0, 0, 0, 4'h0, 0);
         check_all("R2 R3 tx fill");
      end
      // R4 transmit overflow
      cyc(1, 0, 0, 0, 0, 0, 4'h0, 0);
      check_all("R4 tx overflow");
      rd(4'h7, v); chk("R4 raw bit1", 32'(v[1]), 1);
      // R7 clear transmit overflow by its own bit
      wr(4'h8, 32'h8);
      check_all("R7 clear txo");
      // R4 push and pop together at full: no overflow
      cyc(1, 1, 0, 0, 0, 0, 4'h0, 0);
      check_all("R4 push pop at full");
      rd(4'h7, v); chk("R4 no txo on push+pop", 32'(v[1]), 0);
      // R6 transmit drain, empty bit follows level
      for (int i = 0; i < D; i++) begin
         cyc(0, 1, 0, 0, 0, 0, 4'h0, 0);
         check_all("R6 tx drain");
      end

      // R6 receive threshold sweep (threshold 3), then R4 receive overflow
      for (int i = 0; i <= D; i++) begin
         cyc(0, 0, 1, 0, 0, 0, 4'h0, 0);
         check_all("R6 rx threshold 3");
      end
      rd(4'h7, v); chk("R4 raw bit3", 32'(v[3]), 1);

      // R8 mask combinations
      wr(4'h5, 32'h10); check_all("R8 mask rxf");
      chk("R8 irq rxf", 32'(irq), 1);
      wr(4'h5, 32'h08); check_all("R8 mask rxo");
      wr(4'h5, 32'h04); check_all("R8 mask rxu");
      chk("R8 irq idle", 32'(irq), 0);
      wr(4'h5, 32'h7F); check_all("R8 mask all");

      // R5 receive drain and underflow
      for (int i = 0; i <= D; i++) begin
         cyc(0, 0, 0, 1, 0, 0, 4'h0, 0);
         check_all("R5 rx drain");
      end
      rd(4'h7, v); chk("R5 raw bit2", 32'(v[2]), 1);
      // R7 clear underflow only, overflow remains
      wr(4'h8, 32'h2);
      check_all("R7 clear rxu");
      rd(4'h7, v); chk("R7 rxo kept", 32'(v[3]), 1);
      wr(4'h8, 32'h4);
      check_all("R7 clear rxo");
      // R5 push and pop together at empty
      cyc(0, 0, 1, 1, 0, 0, 4'h0, 0);
      check_all("R5 push pop at empty");

      // R11 chip-select inactive
      cyc(0, 0, 0, 0, 1, 0, 4'h0, 0);
      check_all("R11 csi set");
      wr(4'h8, 32'hE);
      check_all("R11 csi kept by own clears");
      // R7 event and clear-all in the same cycle: event wins
      cyc(1, 0, 0, 1, 1, 1, 4'h8, 32'h1);
      check_all("R7 set beats clear");
      rd(4'h7, v); chk("R7 csi after collision", 32'(v[6]), 1);
      wr(4'h8, 32'h1);
      check_all("R7 clear all");

      // R9 threshold write ignored while enabled
      wr(4'h1, 32'd7);
      rd(4'h1, v); chk("R9 thr write enabled", v, 3);
      check_all("R9 thr unchanged");

      // R3 status pass-through bits
      busy = 1'b1; tgt_busy = 1'b1;
      idle();
      check_all("R3 busy bits");
      rd(4'h4, v); chk("R3 status bits 0 and 5", v & 32'h21, 32'h21);
      busy = 1'b0; tgt_busy = 1'b0;

      // R10 disable flushes levels and sticky bits
      for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0, 0, 0, 4'h0, 0);
      cyc(1, 0, 0, 0, 1, 0, 4'h0, 0);
      wr(4'h0, 32'd0);
      idle();
      check_all("R10 flush");
      chk("R10 flush high", 32'(fifo_flush), 1);

      // R6 R9 threshold sweep at both extremes
      for (int k = 0; k < 2; k++) begin
         int t;
         t = (k == 0) ? 0 : D - 1;
         wr(4'h1, 32'(t));
         rd(4'h1, v); chk("R9 thr accepted", v, 32'(t));
         wr(4'h0, 32'd1);
         check_all("R6 rx empty start");
         for (int i = 0; i < D; i++) begin
            cyc(0, 0, 1, 0, 0, 0, 4'h0, 0);
            check_all("R6 rx threshold sweep");
         end
         wr(4'h0, 32'd0);
         idle();
         check_all("R10 flush after sweep");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule